// File: doc/BRIEF.md
# Serial Configuration ROM Responder

This block answers a software-driven serial read protocol on behalf of a small configuration memory. Software toggles a clock bit and a data bit in a control register; the block watches the clock bit, takes one data bit on each low-to-high transition of it, and returns one bit per transition on a data-out line that software reads back through the same register. Every command starts with an 8-bit opcode. The read command is followed by an 8-bit byte address and sixteen returned bits. The status command returns eight zero bits.

The memory holds 64 words of 16 bits and has no write path. It comes up with a 48-bit station address in its first three words and zeros elsewhere. Its last word is a computed filler: the 16-bit sum of all words equals a parameterised signature. The host addresses bytes, and the block drops the lowest address bit to select a word. An opcode it does not recognise, or a word index beyond the store, raises an error flag. The flag stays set until reset.

Top module: `spi_rom_responder`

## Requirements
- R1: After a synchronous reset, `sdo_out` is 0 and `err_out` is 0.
- R2: Only a 0-to-1 change of `sck_in` between two clock samples counts as a serial edge. A clock bit held high for any number of cycles counts once, and `sdi_in` changes made while it is high are ignored.
- R3: The first 8 serial edges of a command shift `sdi_in` into the opcode, most significant bit first. Opcode 0x03 is a read. For a read, the next 8 edges shift in a byte address, MSB first, and the word index is that address shifted right by one.
- R4: For a read, each of the next 16 edges drives `sdo_out` with the next bit of the selected word, MSB first. The value is valid from the clock cycle in which the edge is sampled.
- R5: Words 0, 1 and 2 read as 0xA4A4, 0xB6B6 and 0xC8C8. Words 3 to 62 read as 0.
- R6: Word 63 is filled so that the 16-bit sum of all 64 words equals `SIGNATURE` (default 0xBABA). With the default this gives word 63 = 0x9698.
- R7: Opcode 0x05 (status) makes the next 8 edges drive `sdo_out` to 0.
- R8: After the 16th data bit of a read, or the 8th bit of a status, all counters and shift registers clear. The next edge starts a new opcode.
- R9: A complete opcode other than 0x03 or 0x05 sets `err_out`. The block then waits for a new opcode.
- R10: A read whose word index is 64 or more sets `err_out` and returns sixteen 0 bits.
- R11: Once set, `err_out` stays at 1 until reset, even when later commands complete normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Serial clock bit as written by software |
| sdi_in | input | 1 | Serial data bit from software |
| sdo_out | output | 1 | Serial data bit returned to software |
| err_out | output | 1 | Sticky protocol error flag |

## Verification
The checker tests the cycle-level rules on every cycle:
- the quiet reset state;
- `sdo_out` and `err_out` stay unchanged on any cycle without a serial edge;
- the error flag stays set once raised;
- every status edge drives a 0.

Other behaviour depends on whole command sequences, so only the bench scenarios can show it:
- correct MSB-first ordering of opcode, address and data;
- the byte-to-word address mapping;
- the preset contents and the checksum fill;
- back-to-back commands after the counters clear;
- recovery from an unknown opcode;
- the behaviour of out-of-range reads.

// File: rtl/spi_rom_pkg.sv
package spi_rom_pkg;

    localparam int WORD_W     = 16;
    localparam int OP_W       = 8;
    localparam int ADDR_W     = 8;
    localparam int STAT_BITS  = 8;
    localparam int IDX_W      = ADDR_W - 1;

    localparam logic [OP_W-1:0] OPC_READ = 8'h03;
    localparam logic [OP_W-1:0] OPC_STAT = 8'h05;

    typedef enum logic [1:0] {
        PH_OP   = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_STAT = 2'd3
    } phase_t;

    // Preset content of the leading words (station address).
    function automatic logic [WORD_W-1:0] seed_word(input int idx);
        case (idx)
            0:       return 16'hA4A4;
            1:       return 16'hB6B6;
            2:       return 16'hC8C8;
            default: return '0;
        endcase
    endfunction

    // Full content, with the final word computed so the whole store sums to csum.
    function automatic logic [WORD_W-1:0] fill_word(input int idx,
                                                    input logic [WORD_W-1:0] csum,
                                                    input int words);
        logic [WORD_W-1:0] acc;
        if (idx != words - 1) return seed_word(idx);
        acc = '0;
        for (int k = 0; k < words - 1; k++) acc = acc + seed_word(k);
        return csum - acc;
    endfunction

endpackage

// File: rtl/spi_rise_detect.sv
module spi_rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig_in;
    end

    assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/spi_word_store.sv
module spi_word_store
    import spi_rom_pkg::*;
#(
    parameter int                N_WORDS   = 64,
    parameter logic [WORD_W-1:0] SIGNATURE = 16'hBABA
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word,
    output logic              oob
);
    localparam int SEL_W = $clog2(N_WORDS);

    logic [WORD_W-1:0] rom [N_WORDS];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_rom
        assign rom[g] = fill_word(g, SIGNATURE, N_WORDS);
    end

    always_comb begin
        oob  = (int'(idx) >= N_WORDS);
        word = oob ? '0 : rom[idx[SEL_W-1:0]];
    end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_rom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              sdi,
    input  logic [WORD_W-1:0] word_in,
    input  logic              oob_in,
    output logic [IDX_W-1:0]  look_idx,
    output logic              sdo,
    output logic              err,
    output phase_t            phase
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(OP_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] STAT_LAST = CNT_W'(STAT_BITS - 1);

    phase_t            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [OP_W-1:0]   op_q, op_nx;
    logic [ADDR_W-1:0] addr_q, addr_nx;
    logic [WORD_W-1:0] shreg_q;

    always_comb begin
        op_nx   = {op_q[OP_W-2:0], sdi};
        addr_nx = {addr_q[ADDR_W-2:0], sdi};
    end

    assign look_idx = addr_nx[ADDR_W-1:1];
    assign phase    = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_OP;
            cnt_q   <= '0;
            op_q    <= '0;
            addr_q  <= '0;
            shreg_q <= '0;
            sdo     <= 1'b0;
            err     <= 1'b0;
        end else if (rise) begin
            case (phase_q)
                PH_OP: begin
                    if (cnt_q == OP_LAST) begin
                        cnt_q <= '0;
                        op_q  <= '0;
                        if (op_nx == OPC_READ)      phase_q <= PH_ADDR;
                        else if (op_nx == OPC_STAT) phase_q <= PH_STAT;
                        else                        err     <= 1'b1;
                    end else begin
                        op_q  <= op_nx;
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_ADDR: begin
                    if (cnt_q == ADDR_LAST) begin
                        cnt_q   <= '0;
                        addr_q  <= '0;
                        shreg_q <= oob_in ? '0 : word_in;
                        if (oob_in) err <= 1'b1;
                        phase_q <= PH_DATA;
                    end else begin
                        addr_q <= addr_nx;
                        cnt_q  <= cnt_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    sdo     <= shreg_q[WORD_W-1];
                    shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                    if (cnt_q == DATA_LAST) begin
                        cnt_q   <= '0;
                        phase_q <= PH_OP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_STAT: begin
                    sdo <= 1'b0;
                    if (cnt_q == STAT_LAST) begin
                        cnt_q   <= '0;
                        phase_q <= PH_OP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_OP;
            endcase
        end
    end
endmodule

// File: rtl/spi_rom_responder.sv
module spi_rom_responder
    import spi_rom_pkg::*;
#(
    parameter int                N_WORDS   = 64,
    parameter logic [WORD_W-1:0] SIGNATURE = 16'hBABA
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic sdi_in,
    output logic sdo_out,
    output logic err_out
);
    logic              sck_rise;
    logic [IDX_W-1:0]  look_idx;
    logic [WORD_W-1:0] look_word;
    logic              look_oob;
    phase_t            seq_phase;

    spi_rise_detect u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (sck_in),
        .rise   (sck_rise)
    );

    spi_word_store #(
        .N_WORDS   (N_WORDS),
        .SIGNATURE (SIGNATURE)
    ) u_store (
        .idx  (look_idx),
        .word (look_word),
        .oob  (look_oob)
    );

    spi_cmd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .rise     (sck_rise),
        .sdi      (sdi_in),
        .word_in  (look_word),
        .oob_in   (look_oob),
        .look_idx (look_idx),
        .sdo      (sdo_out),
        .err      (err_out),
        .phase    (seq_phase)
    );
endmodule

// File: rtl/spi_rom_responder_chk.sv
module spi_rom_responder_chk
    import spi_rom_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   rise,
    input logic   sdo,
    input logic   err,
    input phase_t phase
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sdo && !err)); // R1

    AST_SDO_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(sdo)); // R2

    AST_ERR_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(err)); // R9

    AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rise && phase == PH_STAT) |=> !sdo); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R11
endmodule

bind spi_rom_responder spi_rom_responder_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .rise  (sck_rise),
    .sdo   (sdo_out),
    .err   (err_out),
    .phase (seq_phase)
);

// File: tb/sim_spi_rom_responder.sv
module sim_spi_rom_responder;
    logic clk = 1'b0;
    logic rst, sck, sdi;
    logic sdo, err;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    spi_rom_responder u0 (
        .clk     (clk),
        .rst     (rst),
        .sck_in  (sck),
        .sdi_in  (sdi),
        .sdo_out (sdo),
        .err_out (err)
    );

    function automatic logic [15:0] exp_word(input int idx);
        logic [15:0] s;
        s = 16'hA4A4 + 16'hB6B6 + 16'hC8C8;
        if (idx == 0) return 16'hA4A4;
        if (idx == 1) return 16'hB6B6;
        if (idx == 2) return 16'hC8C8;
        if (idx == 63) return 16'hBABA - s;
        return 16'h0000;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One serial edge; clock bit held high for 'hold' cycles while data wiggles.
    task automatic pulse(input bit b, input int hold, output bit so);
        @(negedge clk);
        sdi = b;
        sck = 1'b1;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            sdi = ($urandom % 2) == 1;
        end
        @(negedge clk);
        so  = sdo;
        sck = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input int hold);
        bit so;
        for (int i = 7; i >= 0; i--) pulse(v[i], hold, so);
    endtask

    task automatic read_word(input logic [7:0] addr, input int hold, output logic [15:0] w);
        bit so;
        send_byte(8'h03, hold);
        send_byte(addr, hold);
        for (int i = 15; i >= 0; i--) begin
            pulse(1'b0, hold, so);
            w[i] = so;
        end
    endtask

    initial begin
        logic [15:0] w, sum;
        bit so;
        void'($urandom(32'd1234));
        rst = 1'b1; sck = 1'b0; sdi = 1'b0;
        repeat (3) @(negedge clk);
        check(sdo == 1'b0 && err == 1'b0, "R1 reset", {sdo, err}, 0);
        rst = 1'b0;
        @(negedge clk);

        read_word(8'h00, 0, w); check(w == exp_word(0), "R3 R4 R5 word0", w, exp_word(0));
        read_word(8'h03, 0, w); check(w == exp_word(1), "R3 R5 odd byte addr word1", w, exp_word(1));
        read_word(8'h04, 0, w); check(w == exp_word(2), "R4 R5 word2", w, exp_word(2));
        read_word(8'h7E, 0, w); check(w == 16'h9698, "R6 last word", w, 16'h9698);

        sum = '0;
        for (int k = 0; k < 64; k++) begin
            read_word(8'(2 * k + ($urandom % 2)), 0, w);
            sum = sum + w;
            check(w == exp_word(k), "R5 R8 sweep back-to-back", w, exp_word(k));
        end
        check(sum == 16'hBABA, "R6 store sum", sum, 16'hBABA);

        for (int t = 0; t < 20; t++) begin
            int a, hd;
            a  = $urandom % 128;
            hd = $urandom % 4;
            read_word(8'(a), hd, w);
            check(w == exp_word(a >> 1), "R2 R3 R4 random hold", w, exp_word(a >> 1));
        end

        send_byte(8'h05, 1);
        for (int i = 0; i < 8; i++) begin
            pulse(1'b1, 0, so);
            check(so == 1'b0, "R7 status bit", so, 0);
        end
        read_word(8'h02, 0, w); check(w == exp_word(1), "R8 read after status", w, exp_word(1));
        check(err == 1'b0, "R9 no error on good commands", err, 0);

        send_byte(8'hA5, 0);
        check(err == 1'b1, "R9 bad opcode", err, 1);
        read_word(8'h00, 0, w); check(w == exp_word(0), "R9 recover after bad opcode", w, exp_word(0));
        check(err == 1'b1, "R11 sticky", err, 1);

        rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0; @(negedge clk);
        check(err == 1'b0, "R1 reset clears err", err, 0);
        read_word(8'h80, 0, w);
        check(w == 16'h0000, "R10 out of range data", w, 0);
        check(err == 1'b1, "R10 out of range error", err, 1);
        read_word(8'h05, 0, w);
        check(w == exp_word(2) && err == 1'b1, "R11 err after good read", {w, 15'b0, err}, {exp_word(2), 16'h0001});

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule